// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter Chain

This block keeps wall-clock time and date as packed BCD digits: seconds, minutes, hours, day of week, day of month, month and two-digit year. A one-cycle pulse on `tick_1hz` advances the chain by one second. The pulse is produced elsewhere by dividing a 32.768 kHz reference by 2^15. Each carry ripples through the digits within the same clock edge. The block also brings out two registered carry pulses, one per minute and one per hour. A host bus decoder, which is outside the block, loads individual digits through a write strobe, a 4-bit digit selector and a 4-bit data nibble.

Hours run in 24-hour or 12-hour format. The format flag and an afternoon flag share the hour-tens digit. Leap years are not derived from the year digits. Two spare bits in the day-tens digit hold a code for the year's remainder modulo 4. That code decides whether February has 28 or 29 days, and it steps forward whenever the year advances. Software can therefore pin the leap cycle to any century.

Top module: `rtc_calendar_chain`

## Requirements
- R1: The seconds units count 0..9 and the seconds tens count 0..5. On a tick at 59 the seconds become 00, and `carry_min` is high for exactly the one cycle after that edge and low at all other times.
- R2: The minutes follow the same 00..59 sequence, advanced by the seconds rollover. When the minutes roll from 59 to 00, `carry_hr` is high for the one cycle after that edge.
- R3: With bit 3 of `hr_t` set (24-hour format), the hours count 00..23. Hour-tens bits [1:0] hold the tens value and bit 2 reads 0. The rollover from 23 to 00 advances the date.
- R4: With bit 3 of `hr_t` clear (12-hour format), the hours run 12, 01, .., 11. Bit 2 of `hr_t` (afternoon) toggles on each 11->12 step, and the date advances on the step where it falls from 1 to 0. Writing `hr_t` with bit 3 set forces bit 2 to 0.
- R5: The day of week counts 0..6, wraps to 0 and advances once per date advance.
- R6: The day of month runs from 01 to the month's length: 30 for months 4, 6, 9 and 11, 31 for the other months except February, and 29 for February when the leap code is 00, otherwise 28. A date advance on the last day gives day 01 and advances the month. Month 12 wraps to 01 and advances the year.
- R7: The year counts 00..99 and wraps. The leap code sits in bits {3,2} of `day_t`: 00 means remainder 0, 11 means 1, 10 means 2 and 01 means 3. Each year advance adds 1 to the remainder modulo 4.
- R8: A write loads digit `wr_sel` in this order: 0 sec units, 1 sec tens, 2 min units, 3 min tens, 4 hour units, 5 hour tens, 6 weekday, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens. Seconds tens, minutes tens and weekday keep data bits [2:0]. Month tens keeps bit 0. Every other digit keeps all four bits. Bits that are not stored read 0. Selectors 13..15 change nothing. A write overrides the tick's update of the selected digit, and all other digits still advance from their old values.
- R9: After reset the time reads 00:00:00 in 24-hour format (`hr_t` = 1000b), with weekday 0, day 01, month 01, year 00, leap code 00 and both carries low.
- R10: In a cycle with no tick and no write, no output changes and both carries are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Digit write strobe |
| wr_sel | input | 4 | Digit selector for a write |
| wr_data | input | 4 | Write data nibble |
| sec_u | output | 4 | Seconds units |
| sec_t | output | 4 | Seconds tens |
| min_u | output | 4 | Minutes units |
| min_t | output | 4 | Minutes tens |
| hr_u | output | 4 | Hours units |
| hr_t | output | 4 | {24h flag, afternoon flag, hour tens[1:0]} |
| wday | output | 4 | Day of week 0..6 |
| day_u | output | 4 | Day units |
| day_t | output | 4 | {leap code[1:0], day tens[1:0]} |
| mon_u | output | 4 | Month units |
| mon_t | output | 4 | Month tens |
| yr_u | output | 4 | Year units |
| yr_t | output | 4 | Year tens |
| carry_min | output | 1 | One-cycle pulse after a seconds rollover |
| carry_hr | output | 1 | One-cycle pulse after a minutes rollover |

## Verification
Every digit, including the carry that ripples down the whole chain to the year, is registered at the single rising edge that samples the tick or the write. The result is therefore due exactly one clock after the stimulus, and the two carry pulses are due in that same cycle. The bench changes inputs on the falling edge and compares all thirteen digits and both carries at the following falling edge, against an arithmetic model stepped once per tick. Sweeps cover every hour in both formats, every month end under all four leap codes, all hundred year ends and every weekday.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int DW         = 4;
    localparam int NUM_DIGITS = 13;
    localparam int DATE_WR    = 7;

    typedef logic [DW-1:0] bcd_t;

    // digit selector indices, decoded by the host bus logic
    localparam int SEL_SEC_U = 0;
    localparam int SEL_SEC_T = 1;
    localparam int SEL_MIN_U = 2;
    localparam int SEL_MIN_T = 3;
    localparam int SEL_HR_U  = 4;
    localparam int SEL_HR_T  = 5;
    localparam int SEL_WDAY  = 6;
    localparam int SEL_DAY_U = 7;
    localparam int SEL_DAY_T = 8;
    localparam int SEL_MON_U = 9;
    localparam int SEL_MON_T = 10;
    localparam int SEL_YR_U  = 11;
    localparam int SEL_YR_T  = 12;

    function automatic logic [6:0] bcd_value(input bcd_t tens, input bcd_t units);
        return 7'(tens) * 7'd10 + 7'(units);
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] month, input logic leap);
        logic [6:0] n;
        case (month)
            7'd2:                    n = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: n = 7'd30;
            default:                 n = 7'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_sexa_pair.sv
module rtc_sexa_pair
    import rtc_cal_pkg::*;
#(
    parameter int UNIT_MAX = 9,
    parameter int TENS_MAX = 5,
    parameter int TENS_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic wr_u,
    input  logic wr_t,
    input  bcd_t wr_data,
    output bcd_t unit_o,
    output bcd_t tens_o,
    output logic wrap_o,
    output logic carry_o
);

    localparam bcd_t U_LIM  = bcd_t'(UNIT_MAX);
    localparam bcd_t T_LIM  = bcd_t'(TENS_MAX);
    localparam bcd_t T_MASK = bcd_t'((1 << TENS_W) - 1);

    typedef struct packed {
        bcd_t u;
        bcd_t t;
        logic c;
    } pair_s;

    pair_s pair_d, pair_q;

    assign wrap_o = adv && (pair_q.u >= U_LIM) && (pair_q.t >= T_LIM);

    always_comb begin
        pair_d   = pair_q;
        pair_d.c = 1'b0;
        if (adv) begin
            if (pair_q.u >= U_LIM) begin
                pair_d.u = '0;
                if (pair_q.t >= T_LIM) begin
                    pair_d.t = '0;
                    pair_d.c = 1'b1;
                end else begin
                    pair_d.t = pair_q.t + 4'd1;
                end
            end else begin
                pair_d.u = pair_q.u + 4'd1;
            end
        end
        if (wr_u) pair_d.u = wr_data;
        if (wr_t) pair_d.t = wr_data & T_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign unit_o  = pair_q.u;
    assign tens_o  = pair_q.t;
    assign carry_o = pair_q.c;

    assert_unit_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_u && pair_q.u >= U_LIM) |=> (pair_q.u == 4'd0));

    assert_carry_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !wr_u && !wr_t) |=> (pair_q.c && pair_q.u == 4'd0 && pair_q.t == 4'd0));

    assert_carry_only_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> !pair_q.c);

endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic wr_u,
    input  logic wr_t,
    input  bcd_t wr_data,
    output bcd_t hr_u_o,
    output bcd_t hr_t_o,
    output logic day_adv_o
);

    typedef struct packed {
        bcd_t       u;
        logic [1:0] t;
        logic       pm;
        logic       m24;
    } hour_s;

    hour_s hr_d, hr_q;
    logic  roll;

    always_comb begin
        hr_d = hr_q;
        roll = 1'b0;
        if (adv) begin
            if (hr_q.m24) begin
                if (hr_q.t >= 2'd2 && hr_q.u >= 4'd3) begin
                    hr_d.u = '0;
                    hr_d.t = '0;
                    roll   = 1'b1;
                end else if (hr_q.u >= 4'd9) begin
                    hr_d.u = '0;
                    hr_d.t = hr_q.t + 2'd1;
                end else begin
                    hr_d.u = hr_q.u + 4'd1;
                end
            end else begin
                if (hr_q.t >= 2'd1 && hr_q.u >= 4'd2) begin
                    hr_d.u = 4'd1;
                    hr_d.t = 2'd0;
                end else if (hr_q.t == 2'd1 && hr_q.u == 4'd1) begin
                    hr_d.u  = 4'd2;
                    hr_d.pm = ~hr_q.pm;
                    roll    = hr_q.pm;
                end else if (hr_q.u >= 4'd9) begin
                    hr_d.u = '0;
                    hr_d.t = 2'd1;
                end else begin
                    hr_d.u = hr_q.u + 4'd1;
                end
            end
        end
        if (wr_u) hr_d.u = wr_data;
        if (wr_t) begin
            hr_d.m24 = wr_data[3];
            hr_d.pm  = wr_data[3] ? 1'b0 : wr_data[2];
            hr_d.t   = wr_data[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hr_q <= '{u: '0, t: '0, pm: 1'b0, m24: 1'b1};
        else        hr_q <= hr_d;
    end

    assign hr_u_o    = hr_q.u;
    assign hr_t_o    = {hr_q.m24, hr_q.pm, hr_q.t};
    assign day_adv_o = roll;

    assert_h24_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_u && !wr_t && hr_q.m24 && hr_q.t == 2'd2 && hr_q.u == 4'd3)
        |=> (hr_q.u == 4'd0 && hr_q.t == 2'd0));

    assert_h12_pm_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_u && !wr_t && !hr_q.m24 && hr_q.t == 2'd1 && hr_q.u == 4'd1)
        |=> (hr_q.u == 4'd2 && hr_q.pm != $past(hr_q.pm)));

    assert_h24_clears_pm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_t && wr_data[3]) |=> !hr_q.pm);

endmodule

// File: rtl/rtc_date_ctr.sv
module rtc_date_ctr
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [DATE_WR-1:0] wr_stb,   // wday, day u, day t, mon u, mon t, yr u, yr t
    input  bcd_t               wr_data,
    output bcd_t               wday_o,
    output bcd_t               day_u_o,
    output bcd_t               day_t_o,
    output bcd_t               mon_u_o,
    output bcd_t               mon_t_o,
    output bcd_t               yr_u_o,
    output bcd_t               yr_t_o
);

    typedef struct packed {
        logic [2:0] wd;
        bcd_t       du;
        logic [1:0] dt;
        logic [1:0] code;
        bcd_t       mu;
        logic       mt;
        bcd_t       yu;
        bcd_t       yt;
    } date_s;

    date_s      dt_d, dt_q;
    logic [6:0] day_bin;
    logic [6:0] mon_bin;
    logic [6:0] mon_len;
    logic       mon_roll;
    logic       yr_roll;

    assign day_bin = bcd_value({2'b00, dt_q.dt}, dt_q.du);
    assign mon_bin = bcd_value({3'b000, dt_q.mt}, dt_q.mu);
    assign mon_len = month_days(mon_bin, dt_q.code == 2'b00);

    always_comb begin
        dt_d     = dt_q;
        mon_roll = 1'b0;
        yr_roll  = 1'b0;
        if (adv) begin
            dt_d.wd = (dt_q.wd >= 3'd6) ? 3'd0 : dt_q.wd + 3'd1;
            if (day_bin >= mon_len) begin
                dt_d.du  = 4'd1;
                dt_d.dt  = 2'd0;
                mon_roll = 1'b1;
            end else if (dt_q.du >= 4'd9) begin
                dt_d.du = '0;
                dt_d.dt = dt_q.dt + 2'd1;
            end else begin
                dt_d.du = dt_q.du + 4'd1;
            end
        end
        if (mon_roll) begin
            if (mon_bin >= 7'd12) begin
                dt_d.mu = 4'd1;
                dt_d.mt = 1'b0;
                yr_roll = 1'b1;
            end else if (dt_q.mu >= 4'd9) begin
                dt_d.mu = '0;
                dt_d.mt = 1'b1;
            end else begin
                dt_d.mu = dt_q.mu + 4'd1;
            end
        end
        if (yr_roll) begin
            dt_d.code = dt_q.code - 2'd1;
            if (dt_q.yu >= 4'd9) begin
                dt_d.yu = '0;
                dt_d.yt = (dt_q.yt >= 4'd9) ? 4'd0 : dt_q.yt + 4'd1;
            end else begin
                dt_d.yu = dt_q.yu + 4'd1;
            end
        end
        if (wr_stb[0]) dt_d.wd = wr_data[2:0];
        if (wr_stb[1]) dt_d.du = wr_data;
        if (wr_stb[2]) begin
            dt_d.code = wr_data[3:2];
            dt_d.dt   = wr_data[1:0];
        end
        if (wr_stb[3]) dt_d.mu = wr_data;
        if (wr_stb[4]) dt_d.mt = wr_data[0];
        if (wr_stb[5]) dt_d.yu = wr_data;
        if (wr_stb[6]) dt_d.yt = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dt_q <= '{wd: '0, du: 4'd1, dt: '0, code: '0, mu: 4'd1, mt: 1'b0, yu: '0, yt: '0};
        else        dt_q <= dt_d;
    end

    assign wday_o  = {1'b0, dt_q.wd};
    assign day_u_o = dt_q.du;
    assign day_t_o = {dt_q.code, dt_q.dt};
    assign mon_u_o = dt_q.mu;
    assign mon_t_o = {3'b000, dt_q.mt};
    assign yr_u_o  = dt_q.yu;
    assign yr_t_o  = dt_q.yt;

    assert_wday_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_stb[0] && dt_q.wd >= 3'd6) |=> (dt_q.wd == 3'd0));

    assert_month_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !(|wr_stb) && day_bin >= mon_len) |=> (dt_q.du == 4'd1 && dt_q.dt == 2'd0));

    assert_leap_code_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (yr_roll && !(|wr_stb)) |=> (dt_q.code == $past(dt_q.code) - 2'd1));

endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
    import rtc_cal_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [3:0]       wr_data,
    output logic [3:0]       sec_u,
    output logic [3:0]       sec_t,
    output logic [3:0]       min_u,
    output logic [3:0]       min_t,
    output logic [3:0]       hr_u,
    output logic [3:0]       hr_t,
    output logic [3:0]       wday,
    output logic [3:0]       day_u,
    output logic [3:0]       day_t,
    output logic [3:0]       mon_u,
    output logic [3:0]       mon_t,
    output logic [3:0]       yr_u,
    output logic [3:0]       yr_t,
    output logic             carry_min,
    output logic             carry_hr
);

    localparam int N_PAIRS = 2;

    logic [NUM_DIGITS-1:0] wr_stb;
    logic [N_PAIRS:0]      adv_chain;
    logic [N_PAIRS-1:0]    pair_carry;
    bcd_t                  pair_u [N_PAIRS];
    bcd_t                  pair_t [N_PAIRS];
    logic                  day_adv;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stb
        assign wr_stb[i] = wr_en && (wr_sel == SEL_W'(i));
    end

    assign adv_chain[0] = tick_1hz;

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        rtc_sexa_pair #(
            .UNIT_MAX (9),
            .TENS_MAX (5),
            .TENS_W   (3)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv_chain[p]),
            .wr_u    (wr_stb[2*p]),
            .wr_t    (wr_stb[2*p+1]),
            .wr_data (wr_data),
            .unit_o  (pair_u[p]),
            .tens_o  (pair_t[p]),
            .wrap_o  (adv_chain[p+1]),
            .carry_o (pair_carry[p])
        );
    end

    rtc_hour_ctr u_hour (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv_chain[N_PAIRS]),
        .wr_u      (wr_stb[SEL_HR_U]),
        .wr_t      (wr_stb[SEL_HR_T]),
        .wr_data   (wr_data),
        .hr_u_o    (hr_u),
        .hr_t_o    (hr_t),
        .day_adv_o (day_adv)
    );

    rtc_date_ctr u_date (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (day_adv),
        .wr_stb  (wr_stb[SEL_YR_T:SEL_WDAY]),
        .wr_data (wr_data),
        .wday_o  (wday),
        .day_u_o (day_u),
        .day_t_o (day_t),
        .mon_u_o (mon_u),
        .mon_t_o (mon_t),
        .yr_u_o  (yr_u),
        .yr_t_o  (yr_t)
    );

    assign sec_u     = pair_u[0];
    assign sec_t     = pair_t[0];
    assign min_u     = pair_u[1];
    assign min_t     = pair_t[1];
    assign carry_min = pair_carry[0];
    assign carry_hr  = pair_carry[1];

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wr_en) |=> $stable({sec_u, sec_t, min_u, min_t, hr_u, hr_t, wday,
                                           day_u, day_t, mon_u, mon_t, yr_u, yr_t}));

    assert_idle_no_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |=> (!carry_min && !carry_hr));

    assert_year_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(SEL_YR_T)) |=> (yr_t == $past(wr_data)));

endmodule

// File: tb/rtc_calendar_chain_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_chain_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] sec_u, sec_t, min_u, min_t, hr_u, hr_t, wday;
    logic [3:0] day_u, day_t, mon_u, mon_t, yr_u, yr_t;
    logic       carry_min, carry_hr;

    always #2.5 clk = ~clk;

    rtc_calendar_chain dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
        .hr_u(hr_u), .hr_t(hr_t), .wday(wday), .day_u(day_u), .day_t(day_t),
        .mon_u(mon_u), .mon_t(mon_t), .yr_u(yr_u), .yr_t(yr_t),
        .carry_min(carry_min), .carry_hr(carry_hr)
    );

    int total = 0;
    int bad   = 0;

    // arithmetic model
    int ms, mm, mh, m24, mwd, mday, mmon, myr, mrem;
    logic exp_cmin, exp_chr;

    function automatic int dim(int mon, int rem);
        if (mon == 2) return (rem == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        exp_cmin = 1'b0;
        exp_chr  = 1'b0;
        ms++;
        if (ms == 60) begin
            ms = 0; mm++; exp_cmin = 1'b1;
            if (mm == 60) begin
                mm = 0; mh++; exp_chr = 1'b1;
                if (mh == 24) begin
                    mh = 0;
                    mwd = (mwd + 1) % 7;
                    mday++;
                    if (mday > dim(mmon, mrem)) begin
                        mday = 1; mmon++;
                        if (mmon == 13) begin
                            mmon = 1;
                            myr  = (myr + 1) % 100;
                            mrem = (mrem + 1) % 4;
                        end
                    end
                end
            end
        end
    endtask

    function automatic logic [51:0] exp_vec();
        logic [3:0] ht, hu;
        logic [1:0] code;
        int h12;
        if (m24 != 0) begin
            hu = 4'(mh % 10);
            ht = {2'b10, 2'(mh / 10)};
        end else begin
            h12 = (mh % 12 == 0) ? 12 : mh % 12;
            hu = 4'(h12 % 10);
            ht = {1'b0, (mh >= 12) ? 1'b1 : 1'b0, 2'(h12 / 10)};
        end
        code = 2'((4 - mrem) % 4);
        return {4'(ms % 10), 4'(ms / 10), 4'(mm % 10), 4'(mm / 10), hu, ht, 4'(mwd),
                4'(mday % 10), {code, 2'(mday / 10)}, 4'(mmon % 10), 4'(mmon / 10),
                4'(myr % 10), 4'(myr / 10)};
    endfunction

    function automatic logic [51:0] dut_vec();
        return {sec_u, sec_t, min_u, min_t, hr_u, hr_t, wday,
                day_u, day_t, mon_u, mon_t, yr_u, yr_t};
    endfunction

    task automatic check_all(string tag);
        logic [51:0] e;
        e = exp_vec();
        total++;
        if (dut_vec() !== e || carry_min !== exp_cmin || carry_hr !== exp_chr) begin
            bad++;
            $display("FAIL %s: got %h carries %b%b expected %h carries %b%b",
                     tag, dut_vec(), carry_min, carry_hr, e, exp_cmin, exp_chr);
        end
    endtask

    task automatic check_nib(string tag, int idx, logic [3:0] expv);
        logic [51:0] v;
        v = dut_vec();
        total++;
        if (v[51-4*idx -: 4] !== expv) begin
            bad++;
            $display("FAIL %s: digit %0d got %h expected %h", tag, idx, v[51-4*idx -: 4], expv);
        end
    endtask

    task automatic wr(int sel, logic [3:0] data);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_all();
        logic [51:0] v;
        v = exp_vec();
        for (int i = 0; i < 13; i++) wr(i, v[51-4*i -: 4]);
        @(negedge clk);
        exp_cmin = 1'b0;
        exp_chr  = 1'b0;
    endtask

    task automatic tick_n(int n, string tag);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1'b1;
            model_step();
            @(negedge clk);
            check_all(tag);
        end
        tick_1hz = 1'b0;
        @(negedge clk);
        exp_cmin = 1'b0;
        exp_chr  = 1'b0;
    endtask

    task automatic set_model(int h, int m, int s, int mode24);
        mh = h; mm = m; ms = s; m24 = mode24;
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [51:0] snap;
        ms = 0; mm = 0; mh = 0; m24 = 1; mwd = 0; mday = 1; mmon = 1; myr = 0; mrem = 0;
        exp_cmin = 1'b0; exp_chr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset state");

        // seconds, minutes and the hour carry from reset
        tick_n(3700, "R1 R2 sweep");

        // idle: nothing moves
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_all("R10 idle");
        end

        // every hour boundary in both formats
        for (int mode = 1; mode >= 0; mode--) begin
            for (int h = 0; h < 24; h++) begin
                set_model(h, 59, 59, mode);
                set_all();
                tick_n(1, (mode != 0) ? "R3 hour step" : "R4 hour step");
            end
        end

        // weekday wrap
        for (int w = 0; w < 7; w++) begin
            set_model(23, 59, 59, 1);
            mwd = w; mday = 10; mmon = 5;
            set_all();
            tick_n(1, "R5 weekday");
        end

        // month ends under every leap code
        for (int r = 0; r < 4; r++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int k = 1; k >= 0; k--) begin
                    set_model(23, 59, 59, 1);
                    mrem = r; mmon = mo; myr = 40 + r; mday = dim(mo, r) - k;
                    set_all();
                    tick_n(1, "R6 month end");
                end
            end
        end

        // every year end
        for (int y = 0; y < 100; y++) begin
            set_model(23, 59, 59, (y % 2));
            mmon = 12; mday = 31; myr = y; mrem = y % 4;
            set_all();
            tick_n(1, "R7 year end");
        end

        // write field masking
        begin
            logic [3:0] masks [13];
            masks = '{4'hF, 4'h7, 4'hF, 4'h7, 4'hF, 4'hB, 4'h7,
                      4'hF, 4'hF, 4'hF, 4'h1, 4'hF, 4'hF};
            for (int i = 0; i < 13; i++) begin
                wr(i, 4'hF);
                @(negedge clk);
                check_nib("R8 write mask", i, masks[i]);
            end
        end
        snap = dut_vec();
        for (int s = 13; s < 16; s++) begin
            wr(s, 4'hF);
            @(negedge clk);
            total++;
            if (dut_vec() !== snap) begin
                bad++;
                $display("FAIL R8 unused selector %0d: got %h expected %h", s, dut_vec(), snap);
            end
        end

        // 24-hour write clears the afternoon flag
        wr(5, 4'b0101);
        wr(5, 4'b1100);
        @(negedge clk);
        check_nib("R4 pm clear", 5, 4'b1000);

        // write beats the same-cycle increment
        set_model(10, 20, 9, 1);
        mwd = 2; mday = 14; mmon = 3; myr = 7; mrem = 3;
        set_all();
        tick_1hz = 1'b1; wr_en = 1'b1; wr_sel = 4'd0; wr_data = 4'd3;
        model_step();
        ms = (ms / 10) * 10 + 3;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        check_all("R8 write priority");
        @(negedge clk);
        exp_cmin = 1'b0; exp_chr = 1'b0;
        check_all("R10 after priority");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule